// File: doc/BRIEF.md
# Drive Motor Enable with Hold-Off Timer

This block produces the two active-low motor enables of a two-drive floppy controller. Software supplies a motor request and a drive-select switch. The block asserts the enable of the selected drive one clock after the request. When software drops the request, the motor is normally held on for one second before its enable is released. A mode bit can bypass this delay, so that the enable releases on the next clock.

The one-second interval is a cycle count. Two parameters give the count, one for each input clock rate. A second mode bit tells the block which clock rate is in use, about 7 MHz or about 8 MHz. A status flag reports whether either enable is asserted, including during the hold-off, so that the register interface can present it as a status bit.

Top module: `motor_hold_ctrl`

## Requirements
- R1: After reset, both enables are high (1 = off) and `motor_active` is 0. With no request and no hold-off in progress, both enables stay high.
- R2: A clock edge that samples `motor_on`=1 drives low the enable of the drive named by `drive_sel`: `drive_sel`=0 selects `drv_a_en_n` and `drive_sel`=1 selects `drv_b_en_n`. The other enable is high after that edge.
- R3: If `drive_sel` changes while `motor_on`=1, the newly selected enable goes low at the next edge. The previously selected enable goes high at the same edge, with no hold-off.
- R4: With `timer_bypass`=0 and `clk_fast`=0, call the first edge that samples `motor_on`=0 edge 1. The selected enable stays low through edge SLOW_TICKS-1 and goes high at edge SLOW_TICKS.
- R5: With `clk_fast`=1, the hold-off of R4 uses FAST_TICKS in place of SLOW_TICKS.
- R6: With `timer_bypass`=1, the first edge that samples `motor_on`=0 drives both enables high. This includes an edge that falls part-way through a hold-off.
- R7: An edge that samples `motor_on`=1 during a hold-off cancels the countdown and keeps the enable low. A later release starts a full hold-off again.
- R8: `motor_active` is 1 exactly when either enable is low, including during the hold-off.
- R9: Changes of `drive_sel` during a hold-off (`motor_on`=0) do not change which enable is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| motor_on | input | 1 | Motor request soft switch |
| drive_sel | input | 1 | Drive select soft switch (0 = drive A, 1 = drive B) |
| timer_bypass | input | 1 | Mode bit: 1 releases the motor at once, 0 applies the hold-off |
| clk_fast | input | 1 | Mode bit: 0 = slow input clock, 1 = fast input clock |
| drv_a_en_n | output | 1 | Drive A motor enable, active low |
| drv_b_en_n | output | 1 | Drive B motor enable, active low |
| motor_active | output | 1 | 1 while either enable is low |

## Verification
The assertions check the following on every cycle:
- A request leaves exactly the selected enable low.
- Bypass releases both enables on the next edge.
- A running hold-off keeps its enable stable until the expiry event, and expiry clears the hold.
- The counter stays below the longer limit.
- The status flag always matches the enables.

Only the bench scenarios show the following:
- The exact length of the hold-off at each clock rate.
- That a re-request restarts a full hold-off.
- That the drive select is frozen during a hold-off.

// File: rtl/motor_hold_pkg.sv
package motor_hold_pkg;

  function automatic int unsigned max_ticks(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Hold-off length in cycles for the current clock-rate setting.
  function automatic int unsigned hold_limit(logic fast, int unsigned slow_t,
                                             int unsigned fast_t);
    return fast ? fast_t : slow_t;
  endfunction

endpackage

// File: rtl/motor_hold_timer.sv
module motor_hold_timer
  import motor_hold_pkg::*;
#(
  parameter int unsigned SLOW_TICKS = 7000000,
  parameter int unsigned FAST_TICKS = 8000000,
  parameter int CW = $clog2(max_ticks(SLOW_TICKS, FAST_TICKS) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          motor_on,
  input  logic          bypass,
  input  logic          clk_fast,
  output logic          hold_on,
  output logic          expire,
  output logic [CW-1:0] count
);

  logic [CW-1:0] last_cnt;

  assign last_cnt = CW'(hold_limit(clk_fast, SLOW_TICKS, FAST_TICKS) - 1);
  assign expire   = hold_on && !motor_on && !bypass && (count >= last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_on <= 1'b0;
      count   <= '0;
    end else if (motor_on) begin
      hold_on <= 1'b1;
      count   <= '0;
    end else if (hold_on) begin
      if (bypass || expire) begin
        hold_on <= 1'b0;
        count   <= '0;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/motor_drive_decode.sv
module motor_drive_decode #(
  parameter int NUM_DRIVES = 2,
  parameter int SW = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  motor_on,
  input  logic [SW-1:0]         drive_sel,
  input  logic                  hold_on,
  output logic [NUM_DRIVES-1:0] en_n
);

  logic [SW-1:0] sel_q;

  // The selection is latched only while the request is present,
  // so it is frozen for the duration of a hold-off.
  always_ff @(posedge clk) begin
    if (!rst_n)        sel_q <= '0;
    else if (motor_on) sel_q <= drive_sel;
  end

  for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_en
    assign en_n[i] = !(hold_on && (sel_q == SW'(i)));
  end

endmodule

// File: rtl/motor_hold_ctrl.sv
module motor_hold_ctrl
  import motor_hold_pkg::*;
#(
  parameter int unsigned SLOW_TICKS = 7000000,
  parameter int unsigned FAST_TICKS = 8000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic motor_on,
  input  logic drive_sel,
  input  logic timer_bypass,
  input  logic clk_fast,
  output logic drv_a_en_n,
  output logic drv_b_en_n,
  output logic motor_active
);

  localparam int CW = $clog2(max_ticks(SLOW_TICKS, FAST_TICKS) + 1);

  logic          hold_on;
  logic          expire;
  logic [CW-1:0] count;
  logic [1:0]    en_n;

  motor_hold_timer #(
    .SLOW_TICKS(SLOW_TICKS),
    .FAST_TICKS(FAST_TICKS),
    .CW(CW)
  ) u_timer (
    .clk(clk),
    .rst_n(rst_n),
    .motor_on(motor_on),
    .bypass(timer_bypass),
    .clk_fast(clk_fast),
    .hold_on(hold_on),
    .expire(expire),
    .count(count)
  );

  motor_drive_decode #(
    .NUM_DRIVES(2)
  ) u_decode (
    .clk(clk),
    .rst_n(rst_n),
    .motor_on(motor_on),
    .drive_sel(drive_sel),
    .hold_on(hold_on),
    .en_n(en_n)
  );

  assign drv_a_en_n   = en_n[0];
  assign drv_b_en_n   = en_n[1];
  assign motor_active = !(&en_n);

endmodule

// File: rtl/motor_hold_checker.sv
module motor_hold_checker
  import motor_hold_pkg::*;
#(
  parameter int unsigned SLOW_TICKS = 7000000,
  parameter int unsigned FAST_TICKS = 8000000,
  parameter int CW = $clog2(max_ticks(SLOW_TICKS, FAST_TICKS) + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          motor_on,
  input logic          drive_sel,
  input logic          timer_bypass,
  input logic          drv_a_en_n,
  input logic          drv_b_en_n,
  input logic          motor_active,
  input logic          hold_on,
  input logic          expire,
  input logic [CW-1:0] count
);

  assert_idle_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_on && !motor_on) |=> (drv_a_en_n && drv_b_en_n));

  assert_one_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    motor_on |=> ($countones({~drv_a_en_n, ~drv_b_en_n}) == 1));

  assert_sel_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_on && drive_sel) |=> (!drv_b_en_n && drv_a_en_n));

  assert_sel_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_on && !drive_sel) |=> (!drv_a_en_n && drv_b_en_n));

  assert_hold_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_on && !motor_on && !timer_bypass && !expire)
      |=> (hold_on && $stable({drv_a_en_n, drv_b_en_n})));

  assert_expire_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !hold_on);

  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count < CW'(max_ticks(SLOW_TICKS, FAST_TICKS)));

  assert_bypass_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!motor_on && timer_bypass) |=> (drv_a_en_n && drv_b_en_n));

  assert_active_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    motor_active == !(drv_a_en_n && drv_b_en_n));

endmodule

bind motor_hold_ctrl motor_hold_checker #(
  .SLOW_TICKS(SLOW_TICKS),
  .FAST_TICKS(FAST_TICKS),
  .CW(CW)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .motor_on(motor_on),
  .drive_sel(drive_sel),
  .timer_bypass(timer_bypass),
  .drv_a_en_n(drv_a_en_n),
  .drv_b_en_n(drv_b_en_n),
  .motor_active(motor_active),
  .hold_on(hold_on),
  .expire(expire),
  .count(count)
);

// File: tb/motor_hold_ctrl_test.sv
module motor_hold_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 12;
  localparam int FAST = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic motor_on = 1'b0;
  logic drive_sel = 1'b0;
  logic timer_bypass = 1'b0;
  logic clk_fast = 1'b0;
  logic drv_a_en_n, drv_b_en_n, motor_active;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  motor_hold_ctrl #(.SLOW_TICKS(SLOW), .FAST_TICKS(FAST)) uut (
    .clk(clk), .rst_n(rst_n), .motor_on(motor_on), .drive_sel(drive_sel),
    .timer_bypass(timer_bypass), .clk_fast(clk_fast),
    .drv_a_en_n(drv_a_en_n), .drv_b_en_n(drv_b_en_n),
    .motor_active(motor_active)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected pattern {a_en_n, b_en_n, active}.
  function automatic logic [2:0] want(bit on, bit sel);
    if (!on) return 3'b110;
    return sel ? 3'b101 : 3'b011;
  endfunction

  function automatic logic [2:0] outs();
    return {drv_a_en_n, drv_b_en_n, motor_active};
  endfunction

  task automatic t_reset;
    check("R1", "reset outputs", outs(), want(0, 0));
    step(3);
    check("R1", "idle outputs", outs(), want(0, 0));
  endtask

  task automatic t_select;
    timer_bypass = 1'b0;
    motor_on = 1'b1; drive_sel = 1'b0; step(1);
    check("R2", "drive A on", outs(), want(1, 0));
    check("R8", "active with A", motor_active, 1);
    drive_sel = 1'b1; step(1);
    check("R3", "switch to B", outs(), want(1, 1));
    drive_sel = 1'b0; step(1);
    check("R3", "switch back to A", outs(), want(1, 0));
    timer_bypass = 1'b1; motor_on = 1'b0; step(1);
    check("R6", "bypass off", outs(), want(0, 0));
    timer_bypass = 1'b0; step(1);
  endtask

  task automatic t_hold_slow;
    clk_fast = 1'b0; motor_on = 1'b1; drive_sel = 1'b1; step(1);
    check("R2", "drive B on", outs(), want(1, 1));
    motor_on = 1'b0; step(2);
    drive_sel = 1'b0;
    step(SLOW - 3);
    check("R9", "select ignored in hold", outs(), want(1, 1));
    check("R4", "held at edge SLOW-1", drv_b_en_n, 0);
    check("R8", "active during hold", motor_active, 1);
    step(1);
    check("R4", "released at edge SLOW", outs(), want(0, 0));
  endtask

  task automatic t_hold_fast;
    clk_fast = 1'b1; motor_on = 1'b1; drive_sel = 1'b0; step(1);
    motor_on = 1'b0; step(FAST - 1);
    check("R5", "held at edge FAST-1", outs(), want(1, 0));
    step(1);
    check("R5", "released at edge FAST", outs(), want(0, 0));
    clk_fast = 1'b0;
  endtask

  task automatic t_cancel;
    motor_on = 1'b1; drive_sel = 1'b0; step(1);
    motor_on = 1'b0; step(SLOW - 2);
    motor_on = 1'b1; step(1);
    check("R7", "re-request keeps on", outs(), want(1, 0));
    motor_on = 1'b0; step(SLOW - 1);
    check("R7", "full hold restarted", outs(), want(1, 0));
    step(1);
    check("R7", "restarted hold ends", outs(), want(0, 0));
  endtask

  task automatic t_bypass_mid;
    motor_on = 1'b1; drive_sel = 1'b1; step(1);
    motor_on = 1'b0; step(3);
    check("R4", "mid hold on", outs(), want(1, 1));
    timer_bypass = 1'b1; step(1);
    check("R6", "bypass during hold", outs(), want(0, 0));
    timer_bypass = 1'b0; step(2);
    check("R1", "stays off", outs(), want(0, 0));
  endtask

  initial begin
    step(2);
    t_reset;
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_select;
    t_hold_slow;
    t_hold_fast;
    t_cancel;
    t_bypass_mid;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule